// File: doc/BRIEF.md
# Serial Result Reader for a Delta-Sigma Converter

This block is the host side of a four-wire serial link to a 16-bit delta-sigma converter. Once the converter has had time to finish a conversion, the block pulls chip select low and runs 16 serial clock cycles. On the rising edges it captures the returned bits. While it does so it shifts out a four-bit programming word. Each finished word appears on `result`, together with a one-cycle `result_valid` strobe. The first read after reset is run in full, but its word is thrown away, because that conversion is not trustworthy.

Reads start in one of two ways. A `start` pulse may arrive at any time: it is held until the conversion wait has ended, and it produces exactly one read. While `cont_mode` is high, reads repeat on their own. The speed and sleep bits are taken from `cfg_spd` and `cfg_slp` at the moment chip select falls. The converter acts on a sleep bit only after its next conversion, so the frame that follows a frame carrying sleep=1 waits a longer reference-settling time between chip select falling and the first clock. Raising `abort` while chip select is low ends the frame at once. In that case no result is delivered and the conversion wait starts again.

The control is a four-state machine:
- `ST_CONVERT` waits out the conversion time and moves to `ST_READY` when the timer expires.
- `ST_READY` waits for a request and moves to `ST_SETUP` when one is present; chip select falls here.
- `ST_SETUP` holds the setup delay and moves to `ST_CLOCK` on the first rising clock edge.
- `ST_CLOCK` runs the 16 clock periods. It returns to `ST_CONVERT` after the trailing low half-period.
- From `ST_SETUP` or `ST_CLOCK`, an abort jumps straight back to `ST_CONVERT`.

Top module: `adc_spi_reader`

## Requirements
- R1: During reset `cs_n` is 1, `sck` is 0, `result_valid` is 0 and `result` is 0.
- R2: `cs_n` never falls until at least CONV_CYC clock cycles have passed since it last rose, or since reset was released.
- R3: The first frame after reset starts without any request and runs all 16 clock periods. It raises no `result_valid`.
- R4: `sck` is 0 whenever `cs_n` is 1. After `cs_n` falls, `sck` stays low for the setup delay and then makes exactly 16 rising edges. Every high and low half-period lasts CLK_DIV cycles, and one more low half-period follows the 16th falling edge before `cs_n` rises.
- R5: `sdo` is sampled on each `sck` rising edge, most significant bit first. When `cs_n` rises after a complete frame, `result` takes the 16 sampled bits and `result_valid` is high for exactly that one cycle. At all other times `result` holds its value.
- R6: `sdi` carries 1, 0, spd, slp on the first four rising edges and 0 on the other twelve. spd and slp are the values of `cfg_spd` and `cfg_slp` in the cycle chip select falls.
- R7: If `abort` is 1 in a cycle while `cs_n` is 0, the next cycle has `cs_n` = 1 and `sck` = 0. That frame raises no `result_valid` and leaves `result` unchanged, and the R2 wait restarts.
- R8: A one-cycle `start` pulse given during the conversion wait is held and causes exactly one frame once the wait ends. With no request, no new frame starts.
- R9: While `cont_mode` is 1, a new frame starts as soon as each conversion wait ends, and no `start` is needed.
- R10: The setup delay (cycles from `cs_n` falling to the first `sck` rise) is REF_CYC if the last slp bit delivered on a fourth rising edge was 1. Otherwise it is CLK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request for a single read |
| cont_mode | input | 1 | Repeat reads back to back while high |
| abort | input | 1 | Ends the current frame early by raising chip select |
| cfg_spd | input | 1 | Speed bit sent in the programming word |
| cfg_slp | input | 1 | Sleep bit sent in the programming word |
| sdo | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| sdi | output | 1 | Serial programming data to the converter |
| result | output | DATA_BITS | Last delivered conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
Most faults in the state register or the shared timer show up in `cs_n` or `sck` within one half-period. Examples are an edge off by a cycle, a seventeenth clock or a missing trailing low phase. Because the reference model runs alongside on every clock, such faults are caught in the first frame that exercises them. A stale sleep flag or a lost pending request is quieter: it shows only in the following frame, either as a setup delay of the wrong length or as a frame that starts or fails to start. A wrong first-result flag shows as a strobe in the very first frame, or as a missing one in the second.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_READY   = 2'd1,
        ST_SETUP   = 2'd2,
        ST_CLOCK   = 2'd3
    } rd_state_t;

    // Width of the programming word: two enable marks, speed, sleep.
    localparam int unsigned PROG_BITS = 4;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
// Loadable down-counter; done is high while the count sits at zero.
module adc_rd_timer #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= INIT;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/adc_rd_shifter.sv
`timescale 1ns/1ps
// Frame shifter: programming word out on sdi, returned bits in from sdo.
module adc_rd_shifter #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cfg,
    input  logic          sample,
    input  logic          advance,
    input  logic          sdo_in,
    output logic          sdi_out,
    output logic [N-1:0]  data
);

    logic [N-1:0] out_sr;
    logic [N-1:0] in_sr;
    logic [N-1:0] load_word;

    generate
        if (N > CW) begin : g_pad
            assign load_word = {cfg, {(N-CW){1'b0}}};
        end else begin : g_trim
            assign load_word = cfg[CW-1 -: N];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sr <= '0;
            in_sr  <= '0;
        end else if (load) begin
            out_sr <= load_word;
            in_sr  <= '0;
        end else begin
            if (advance) out_sr <= {out_sr[N-2:0], 1'b0};
            if (sample)  in_sr  <= {in_sr[N-2:0], sdo_in};
        end
    end

    assign sdi_out = out_sr[N-1];
    assign data    = in_sr;

endmodule

// File: rtl/adc_spi_reader.sv
`timescale 1ns/1ps
module adc_spi_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned CLK_DIV   = 50,
    parameter int unsigned CONV_CYC  = 3_320_000,
    parameter int unsigned REF_CYC   = 2_400_000,
    parameter int unsigned DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cont_mode,
    input  logic                 abort,
    input  logic                 cfg_spd,
    input  logic                 cfg_slp,
    input  logic                 sdo,
    output logic                 cs_n,
    output logic                 sck,
    output logic                 sdi,
    output logic [DATA_BITS-1:0] result,
    output logic                 result_valid
);

    localparam int unsigned TMAX = max3(CLK_DIV, CONV_CYC, REF_CYC);
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned BW   = $clog2(DATA_BITS + 1);
    localparam logic [TW-1:0] T_DIV  = TW'(CLK_DIV - 1);
    localparam logic [TW-1:0] T_CONV = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0] T_REF  = TW'(REF_CYC - 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(DATA_BITS);
    localparam logic [BW-1:0] SLP_LATCH  = BW'(PROG_BITS - 1);

    rd_state_t            state_q, state_d;
    logic                 tmr_done, tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 sh_load, sample, advance, to_conv, fin;
    logic                 go;
    logic [BW-1:0]        bit_cnt;
    logic                 req_pend, first_pend, ref_off, frame_slp;
    logic [DATA_BITS-1:0] sh_data;
    logic [PROG_BITS-1:0] prog_word;

    assign prog_word = {1'b1, 1'b0, cfg_spd, cfg_slp};
    assign go        = first_pend | req_pend | start | cont_mode;
    assign fin       = (state_q == ST_CLOCK) && tmr_done && !sck && (bit_cnt == LAST_BIT);

    adc_rd_timer #(.W(TW), .INIT(T_CONV)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    adc_rd_shifter #(.N(DATA_BITS), .CW(PROG_BITS)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .cfg     (prog_word),
        .sample  (sample),
        .advance (advance),
        .sdo_in  (sdo),
        .sdi_out (sdi),
        .data    (sh_data)
    );

    // Next state and per-cycle controls.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = T_DIV;
        sh_load  = 1'b0;
        sample   = 1'b0;
        advance  = 1'b0;
        to_conv  = 1'b0;
        unique case (state_q)
            ST_CONVERT: begin
                if (tmr_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (go) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = ref_off ? T_REF : T_DIV;
                    sh_load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (abort) begin
                    state_d = ST_CONVERT;
                    to_conv = 1'b1;
                end else if (tmr_done) begin
                    state_d  = ST_CLOCK;
                    tmr_load = 1'b1;
                    sample   = 1'b1;
                end
            end
            ST_CLOCK: begin
                if (abort || fin) begin
                    state_d = ST_CONVERT;
                    to_conv = 1'b1;
                end else if (tmr_done) begin
                    tmr_load = 1'b1;
                    sample   = !sck;
                    advance  = sck;
                end
            end
        endcase
        if (to_conv) begin
            tmr_load = 1'b1;
            tmr_val  = T_CONV;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONVERT;
        else        state_q <= state_d;
    end

    // Outputs and frame bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n         <= 1'b1;
            sck          <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
            bit_cnt      <= '0;
            req_pend     <= 1'b0;
            first_pend   <= 1'b1;
            ref_off      <= 1'b0;
            frame_slp    <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            cs_n         <= (state_d == ST_CONVERT) || (state_d == ST_READY);
            req_pend     <= (req_pend | start) & ~(state_q == ST_READY && go);
            if (sh_load) begin
                frame_slp <= cfg_slp;
                bit_cnt   <= '0;
            end
            if (sample) begin
                sck     <= 1'b1;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == SLP_LATCH) ref_off <= frame_slp;
            end
            if (advance) sck <= 1'b0;
            if (to_conv) begin
                sck        <= 1'b0;
                first_pend <= 1'b0;
            end
            if (fin && !abort && !first_pend) begin
                result_valid <= 1'b1;
                result       <= sh_data;
            end
        end
    end

endmodule

// File: rtl/adc_spi_reader_chk.sv
`timescale 1ns/1ps
module adc_spi_reader_chk #(
    parameter int unsigned CONV_CYC  = 4,
    parameter int unsigned DATA_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 sck,
    input logic                 sdi,
    input logic                 abort,
    input logic                 result_valid,
    input logic [DATA_BITS-1:0] result
);

    int unsigned gap;
    int unsigned rises;
    logic        sck_prev;
    logic        rise_now;

    assign rise_now = sck & ~sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap      <= 0;
            rises    <= 0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck;
            if (cs_n) begin
                if (gap != 32'hFFFF_FFFF) gap <= gap + 1;
            end else begin
                gap <= 0;
            end
            if (cs_n)          rises <= 0;
            else if (rise_now) rises <= rises + 1;
        end
    end

    p_conv_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap >= CONV_CYC));

    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_setup_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sck);

    p_rise_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_now |-> (rises < DATA_BITS));

    p_valid_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(cs_n));

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    p_enable_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && rises == 0) |-> sdi);

    p_enable_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && rises == 1) |-> !sdi);

    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && rises >= 4) |-> !sdi);

    p_abort_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !cs_n) |=> (cs_n && !sck && !result_valid));

endmodule

bind adc_spi_reader adc_spi_reader_chk #(
    .CONV_CYC  (CONV_CYC),
    .DATA_BITS (DATA_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .sdi          (sdi),
    .abort        (abort),
    .result_valid (result_valid),
    .result       (result)
);

// File: tb/sim_adc_spi_reader.sv
`timescale 1ns/1ps
module sim_adc_spi_reader;

    localparam int D = 2;
    localparam int C = 40;
    localparam int R = 10;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cont_mode = 1'b0, abort = 1'b0;
    logic cfg_spd = 1'b0, cfg_slp = 1'b0, sdo = 1'b0;
    logic cs_n, sck, sdi, result_valid;
    logic [15:0] result;

    always #2.5 clk = ~clk;

    adc_spi_reader #(.CLK_DIV(D), .CONV_CYC(C), .REF_CYC(R), .DATA_BITS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
        .abort(abort), .cfg_spd(cfg_spd), .cfg_slp(cfg_slp), .sdo(sdo),
        .cs_n(cs_n), .sck(sck), .sdi(sdi), .result(result),
        .result_valid(result_valid)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] word_of(input int n);
        return 16'hB4E1 ^ 16'(n * 16'h2D3B);
    endfunction

    // Converter stand-in: next bit after each falling sck, new word per frame.
    int   dev_n = 0, dev_falls = 0;
    logic dev_cs_prev = 1'b1, dev_sck_prev = 1'b0;
    logic [15:0] dev_w;
    always @(negedge clk) begin
        if (cs_n) begin
            if (!dev_cs_prev) dev_n++;
            dev_falls = 0;
        end else if (dev_sck_prev && !sck) begin
            dev_falls++;
        end
        dev_cs_prev  = cs_n;
        dev_sck_prev = sck;
        dev_w = word_of(dev_n);
        sdo   = (dev_falls < N) ? dev_w[15 - dev_falls] : 1'b0;
    end

    // Behavioural reference, advanced on each rising clock.
    int   m_gap, m_u, m_s, m_n, m_k, m_idx;
    bit   m_cs, m_sck, m_sdi, m_valid, m_req, m_first, m_refoff, m_live, m_req_now, m_go;
    logic [3:0]  m_cfg;
    logic [15:0] m_result;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cs = 1; m_sck = 0; m_sdi = 0; m_valid = 0; m_req = 0; m_first = 1;
            m_refoff = 0; m_gap = 0; m_u = 0; m_s = D; m_n = 0; m_result = '0; m_live = 0;
            m_cfg = '0;
        end else begin
            m_live = 1;
            m_valid = 0;
            m_req_now = m_req || start;
            if (m_cs) begin
                m_go = m_first || m_req_now || cont_mode;
                if (m_gap >= C && m_go) begin
                    m_cs = 0; m_u = 0; m_sck = 0; m_req = 0;
                    m_s = m_refoff ? R : D;
                    m_cfg = {1'b1, 1'b0, cfg_spd, cfg_slp};
                    m_sdi = m_cfg[3];
                end else begin
                    m_gap++;
                    m_req = m_req_now;
                end
            end else begin
                m_req = m_req_now;
                if (abort) begin
                    m_cs = 1; m_sck = 0; m_gap = 0; m_first = 0; m_n++;
                end else begin
                    m_u++;
                    if (m_u == m_s + 2 * N * D) begin
                        m_cs = 1; m_sck = 0; m_gap = 0;
                        if (!m_first) begin
                            m_valid = 1;
                            m_result = word_of(m_n);
                        end
                        m_first = 0;
                        m_n++;
                    end else begin
                        if (m_u < m_s) begin
                            m_sck = 0; m_idx = 0;
                        end else begin
                            m_k = (m_u - m_s) / D;
                            m_sck = (m_k % 2 == 0);
                            m_idx = (m_k + 1) / 2;
                            if (m_u == m_s + 6 * D) m_refoff = m_cfg[0];
                        end
                        m_sdi = (m_idx < 4) ? m_cfg[3 - m_idx] : 1'b0;
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (m_live) begin
            chk("R2 cs_n vs model", cs_n, m_cs);
            chk("R4 sck vs model", sck, m_sck);
            if (!m_cs) chk("R6 sdi vs model", sdi, m_sdi);
            chk("R5 result_valid vs model", result_valid, m_valid);
            chk("R5 result vs model", result, m_result);
        end
    end

    // Frame monitor: frame count, strobe count, setup length.
    int frames = 0, valids = 0, su_cnt = 0, last_setup = -1;
    bit meas = 0;
    logic mon_cs_prev = 1'b1;
    always @(negedge clk) begin
        if (mon_cs_prev && !cs_n) begin
            frames++;
            su_cnt = 0;
            meas = 1;
        end
        if (meas && !cs_n) begin
            if (sck) begin
                last_setup = su_cnt;
                meas = 0;
            end else begin
                su_cnt++;
            end
        end
        if (result_valid) valids++;
        mon_cs_prev = cs_n;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic run_to_frame_end(input int target);
        while (!(frames >= target && cs_n)) step();
        step();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired (frames=%0d expected run to end)", frames);
        finish_run();
    end

    initial begin
        repeat (4) step();
        // R1: values held during reset
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sck in reset", sck, 0);
        chk("R1 result_valid in reset", result_valid, 0);
        chk("R1 result in reset", result, 0);
        rst_n = 1'b1;

        // R3: automatic first frame, no strobe
        run_to_frame_end(1);
        chk("R3 no strobe on first frame", valids, 0);
        chk("R3 first frame setup", last_setup, D);

        // R8: nothing starts without a request
        repeat (150) step();
        chk("R8 idle without request", frames, 1);

        // R5/R6: single read with spd=1
        cfg_spd = 1'b1; cfg_slp = 1'b0;
        pulse_start();
        run_to_frame_end(2);
        chk("R5 strobe count", valids, 1);
        chk("R5 result word", result, word_of(1));
        chk("R4 setup one half-period", last_setup, D);

        // R8: request during conversion wait is held
        pulse_start();
        repeat (10) step();
        chk("R8 held during wait", cs_n, 1);
        run_to_frame_end(3);
        chk("R8 held request served", valids, 2);
        chk("R8 held request word", result, word_of(2));
        repeat (100) step();
        chk("R8 one frame per request", frames, 3);

        // R10: sleep bit lengthens setup of the following frame
        cfg_spd = 1'b0; cfg_slp = 1'b1;
        pulse_start();
        run_to_frame_end(4);
        chk("R10 programming frame setup", last_setup, D);
        cfg_slp = 1'b0;
        pulse_start();
        run_to_frame_end(5);
        chk("R10 reference wait setup", last_setup, R);
        pulse_start();
        run_to_frame_end(6);
        chk("R10 setup after wake", last_setup, D);
        chk("R10 strobes so far", valids, 5);

        // R7: abort in mid-frame
        pulse_start();
        while (cs_n) step();
        repeat (9 * D) step();
        abort = 1'b1;
        step();
        abort = 1'b0;
        chk("R7 cs_n high after abort", cs_n, 1);
        chk("R7 sck low after abort", sck, 0);
        chk("R7 no strobe on abort", result_valid, 0);
        repeat (20) step();
        chk("R7 no strobe after abort", valids, 5);
        chk("R7 result kept", result, word_of(5));
        pulse_start();
        run_to_frame_end(8);
        chk("R7 next frame word", result, word_of(7));

        // R9: continuous reads
        cont_mode = 1'b1;
        run_to_frame_end(11);
        cont_mode = 1'b0;
        repeat (150) step();
        chk("R9 continuous frames", frames, 11);
        chk("R9 continuous strobes", valids, 9);
        chk("R9 last continuous word", result, word_of(10));

        finish_run();
    end

endmodule